// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a direct-mapped cache that sits between a processor request port and a slower memory. The default size is 1 KB, made of 32 lines of 32 bytes. Each processor request is one 32-bit word. The controller splits the request address into a tag, a line index and a byte offset. A hit needs the indexed line to be valid and its stored tag to match the address tag. A hit completes in the cycle it is presented. A miss first writes back the old line if needed, then fetches the whole new line in eight beats, and then completes the request as a hit.

Two parameters set the policy. `WRITE_BACK` selects between two write policies:
- **Write-back:** stores stay in the cache, and a dirty line goes out to memory only when it is replaced.
- **Write-through:** every store also goes into a small posted-write queue, which drains to memory on its own.

`WRITE_ALLOC` decides what a store miss does:
- **Allocate:** fetch the line first, then write it.
- **No-allocate:** send the store straight to memory through the queue and leave the cache untouched.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stable until it sees `cpu_ack`. It drops or changes the request after the clock edge at which the acknowledge was seen.

Top module: `dm_cache`

## Requirements
- R1: The byte offset is the low log2(LINE_BYTES) address bits (4:0 by default). The line index is the next log2(NUM_LINES) bits (9:5 by default). The tag is all remaining upper bits. Two addresses with the same index and different tags evict each other, while different indices never interfere.
- R2: A request hits only when the indexed line is valid and its tag matches. A read hit raises `cpu_ack` combinationally in the cycle it is presented, with the addressed word on `cpu_rdata`.
- R3: A read miss issues exactly one line request at the line-aligned address. It then accepts eight data beats in word order, installs the line, and then acknowledges with the fetched word. Later accesses to that line hit.
- R4: Reset clears every valid and dirty bit. Right after reset, `cpu_ack`, `mem_rreq_valid` and `mem_wvalid` are low, and the first access misses.
- R5: In write-back mode, a store hit updates only the cache word, sets the line's dirty bit, and produces no memory write.
- R6: In write-back mode, a miss that replaces a dirty line first writes the eight victim words to consecutive word addresses under the victim's tag, and only then requests the new line. A clean victim causes no write.
- R7: In write-through mode, a store that is acknowledged is pushed into a queue of WB_DEPTH entries (default 4). A store hit also updates the cache word. The queue sends one word per accepted write beat, in arrival order.
- R8: A store that needs the queue while it is full is held without acknowledge until an entry drains.
- R9: With write-allocate, a store miss fetches the line, then writes the word into it (setting dirty in write-back mode).
- R10: With no-allocate, a store miss goes to memory only, through the queue, and the cache contents do not change. A following read of that line still misses.
- R11: A line fetch is not requested while the queue holds a store to the same line, so the fetched data includes that store.
- R12: While `mem_wvalid` is high and `mem_wready` is low, the write address and data hold. While `mem_rreq_valid` is high and `mem_rreq_ready` is low, the request address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request pending |
| cpu_we | input | 1 | Request is a store |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` |
| mem_rreq_valid | output | 1 | Line fetch request |
| mem_rreq_ready | input | 1 | Memory accepts the line request |
| mem_rreq_addr | output | ADDR_W | Line-aligned fetch address |
| mem_rvalid | input | 1 | One fetched word is present |
| mem_rdata | input | DATA_W | Fetched word |
| mem_wvalid | output | 1 | Word write offered |
| mem_wready | input | 1 | Memory accepts the word write |
| mem_waddr | output | ADDR_W | Word write address |
| mem_wdata | output | DATA_W | Word write data |

## Verification
The bench builds two copies of the block, each with four lines so that the index is only two bits wide.
- **Write-back copy:** write-back with write-allocate. With only four lines, a sweep across a 4 KB address window constantly forces conflicting tags, dirty evictions and clean replacements.
- **Write-through copy:** write-through with no-allocate. Its memory model accepts a write only one cycle in eight, so the queue fills, stores stall, and reads of a just-stored line meet a pending queued write.

Every load in both copies is compared against a shadow memory in the bench.

// File: rtl/dm_cache.sv
`timescale 1ns/1ps
module dm_cache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int NUM_LINES   = 32,
  parameter int WB_DEPTH    = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rreq_valid,
  input  logic              mem_rreq_ready,
  output logic [ADDR_W-1:0] mem_rreq_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int WORD_OFF = $clog2(DATA_W / 8);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int WPL      = LINE_BYTES / (DATA_W / 8);
  localparam int BEAT_W   = $clog2(WPL);
  localparam int PTR_W    = $clog2(WB_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FREQ, S_FILL} state_t;

  state_t               st_q;
  logic [BEAT_W-1:0]    beat_q;
  logic [TAG_W-1:0]     tag_q   [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [DATA_W-1:0]    data_q  [NUM_LINES*WPL];
  logic [ADDR_W-1:0]    wb_addr [WB_DEPTH];
  logic [DATA_W-1:0]    wb_data [WB_DEPTH];
  logic [PTR_W-1:0]     wb_rd, wb_wr;
  logic [PTR_W:0]       wb_cnt;
  logic                 line_pending;

  wire [IDX_W-1:0]  idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  atag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [BEAT_W-1:0] word = cpu_addr[WORD_OFF +: BEAT_W];

  wire line_hit     = valid_q[idx] && (tag_q[idx] == atag);
  wire wb_full      = (wb_cnt == (PTR_W+1)'(WB_DEPTH));
  wire wb_empty     = (wb_cnt == '0);
  wire victim_dirty = WRITE_BACK && valid_q[idx] && dirty_q[idx];
  wire need_fill    = !line_hit && (!cpu_we || WRITE_ALLOC);
  wire need_push    = cpu_we && (WRITE_BACK ? (!line_hit && !WRITE_ALLOC)
                                            : (line_hit || !WRITE_ALLOC));
  wire idle_req     = (st_q == S_IDLE) && cpu_req;
  wire evicting     = (st_q == S_EVICT);
  wire last_beat    = (beat_q == BEAT_W'(WPL - 1));

  assign cpu_ack = idle_req && !need_fill && !(need_push && wb_full);
  wire wb_push   = cpu_ack && need_push;
  wire wb_pop    = !evicting && !wb_empty && mem_wready;
  wire miss_go   = idle_req && need_fill && !line_pending && !(victim_dirty && !wb_empty);

  assign cpu_rdata      = data_q[{idx, word}];
  assign mem_rreq_valid = (st_q == S_FREQ);
  assign mem_rreq_addr  = {atag, idx, {OFF_W{1'b0}}};
  assign mem_wvalid     = evicting || !wb_empty;
  assign mem_waddr      = evicting ? {tag_q[idx], idx, beat_q, {WORD_OFF{1'b0}}} : wb_addr[wb_rd];
  assign mem_wdata      = evicting ? data_q[{idx, beat_q}] : wb_data[wb_rd];

  always_comb begin
    line_pending = 1'b0;
    for (int i = 0; i < WB_DEPTH; i++) begin
      if (({1'b0, PTR_W'(i) - wb_rd} < wb_cnt) &&
          (wb_addr[i][ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]))
        line_pending = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      beat_q  <= '0;
      valid_q <= '0;
      dirty_q <= '0;
      wb_rd   <= '0;
      wb_wr   <= '0;
      wb_cnt  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (miss_go) begin
            beat_q <= '0;
            st_q   <= victim_dirty ? S_EVICT : S_FREQ;
          end else if (cpu_ack && cpu_we && line_hit && WRITE_BACK) begin
            dirty_q[idx] <= 1'b1;
          end
        end
        S_EVICT: if (mem_wready) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            dirty_q[idx] <= 1'b0;
            st_q         <= S_FREQ;
          end
        end
        S_FREQ: if (mem_rreq_ready) begin
          beat_q <= '0;
          st_q   <= S_FILL;
        end
        S_FILL: if (mem_rvalid) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
            st_q         <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (wb_push) wb_wr <= wb_wr + 1'b1;
      if (wb_pop)  wb_rd <= wb_rd + 1'b1;
      wb_cnt <= wb_cnt + (PTR_W+1)'(wb_push) - (PTR_W+1)'(wb_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_FILL && mem_rvalid) begin
      data_q[{idx, beat_q}] <= mem_rdata;
      if (last_beat) tag_q[idx] <= atag;
    end else if (cpu_ack && cpu_we && line_hit) begin
      data_q[{idx, word}] <= cpu_wdata;
    end
    if (wb_push) begin
      wb_addr[wb_wr] <= cpu_addr;
      wb_data[wb_wr] <= cpu_wdata;
    end
  end

  // R2
  read_ack_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !cpu_we |-> line_hit);

  // R5
  wb_dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    WRITE_BACK && cpu_ack && cpu_we && line_hit |=> dirty_q[$past(idx)]);

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && need_push && wb_full |-> !cpu_ack);

  // R11
  fill_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rreq_valid |-> !line_pending);

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));

  // R12
  rreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rreq_valid && !mem_rreq_ready |=> mem_rreq_valid && $stable(mem_rreq_addr));
endmodule

// File: tb/sim_dm_cache.sv
`timescale 1ns/1ps
module sim_mem #(parameter bit SLOW = 1'b0) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rreq_valid,
  output logic        rreq_ready,
  input  logic [31:0] rreq_addr,
  output logic        rvalid,
  output logic [31:0] rdata,
  input  logic        wvalid,
  output logic        wready,
  input  logic [31:0] waddr,
  input  logic [31:0] wdata
);
  logic [31:0] mem [1024];
  int fills, writes;
  logic busy;
  logic [9:0] base;
  logic [2:0] beat;
  logic [7:0] cyc;

  assign rreq_ready = !busy;
  assign wready = SLOW ? (cyc[2:0] == 3'd0) : (cyc[1:0] != 2'd0);

  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rvalid <= 1'b0; rdata <= '0; cyc <= '0;
      base <= '0; beat <= '0; fills <= 0; writes <= 0;
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hC0DE_0000 + i;
    end else begin
      cyc <= cyc + 8'd1;
      if (!busy) begin
        rvalid <= 1'b0;
        if (rreq_valid) begin
          busy <= 1'b1; base <= rreq_addr[11:2]; beat <= '0; fills <= fills + 1;
        end
      end else begin
        rvalid <= 1'b1;
        rdata  <= mem[base + 10'(beat)];
        beat   <= beat + 3'd1;
        if (beat == 3'd7) busy <= 1'b0;
      end
      if (wvalid && wready) begin
        mem[waddr[11:2]] <= wdata;
        writes <= writes + 1;
      end
    end
  end
endmodule

module sim_dm_cache;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;

  logic c0_req = 1'b0, c0_we = 1'b0, c0_ack;
  logic [31:0] c0_addr = '0, c0_wdata = '0, c0_rdata;
  logic m0_rv, m0_rr, m0_dv, m0_wv, m0_wr;
  logic [31:0] m0_ra, m0_dd, m0_wa, m0_wd;
  logic c1_req = 1'b0, c1_we = 1'b0, c1_ack;
  logic [31:0] c1_addr = '0, c1_wdata = '0, c1_rdata;
  logic m1_rv, m1_rr, m1_dv, m1_wv, m1_wr;
  logic [31:0] m1_ra, m1_dd, m1_wa, m1_wd;

  dm_cache #(.NUM_LINES(4), .WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(c0_req), .cpu_we(c0_we), .cpu_addr(c0_addr),
    .cpu_wdata(c0_wdata), .cpu_ack(c0_ack), .cpu_rdata(c0_rdata),
    .mem_rreq_valid(m0_rv), .mem_rreq_ready(m0_rr), .mem_rreq_addr(m0_ra),
    .mem_rvalid(m0_dv), .mem_rdata(m0_dd), .mem_wvalid(m0_wv), .mem_wready(m0_wr),
    .mem_waddr(m0_wa), .mem_wdata(m0_wd));
  sim_mem #(.SLOW(1'b0)) mm0 (
    .clk(clk), .rst_n(rst_n), .rreq_valid(m0_rv), .rreq_ready(m0_rr), .rreq_addr(m0_ra),
    .rvalid(m0_dv), .rdata(m0_dd), .wvalid(m0_wv), .wready(m0_wr), .waddr(m0_wa), .wdata(m0_wd));

  dm_cache #(.NUM_LINES(4), .WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_req(c1_req), .cpu_we(c1_we), .cpu_addr(c1_addr),
    .cpu_wdata(c1_wdata), .cpu_ack(c1_ack), .cpu_rdata(c1_rdata),
    .mem_rreq_valid(m1_rv), .mem_rreq_ready(m1_rr), .mem_rreq_addr(m1_ra),
    .mem_rvalid(m1_dv), .mem_rdata(m1_dd), .mem_wvalid(m1_wv), .mem_wready(m1_wr),
    .mem_waddr(m1_wa), .mem_wdata(m1_wd));
  sim_mem #(.SLOW(1'b1)) mm1 (
    .clk(clk), .rst_n(rst_n), .rreq_valid(m1_rv), .rreq_ready(m1_rr), .rreq_addr(m1_ra),
    .rvalid(m1_dv), .rdata(m1_dd), .wvalid(m1_wv), .wready(m1_wr), .waddr(m1_wa), .wdata(m1_wd));

  int checks = 0, errors = 0, hold_bad = 0;
  logic [31:0] sm0 [1024];
  logic [31:0] sm1 [1024];
  logic [31:0] rd_last;
  int wc_last;
  logic h0p = 1'b0, h1p = 1'b0;
  logic [31:0] h0a, h0d, h1a, h1d;

  always @(negedge clk) begin
    if (!rst_n) begin
      h0p = 1'b0; h1p = 1'b0;
    end else begin
      if (h0p && !(m0_wv && m0_wa == h0a && m0_wd == h0d)) hold_bad++;
      if (h1p && !(m1_wv && m1_wa == h1a && m1_wd == h1d)) hold_bad++;
      h0p = m0_wv && !m0_wr; h0a = m0_wa; h0d = m0_wd;
      h1p = m1_wv && !m1_wr; h1a = m1_wa; h1d = m1_wd;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input int which, input bit we, input logic [31:0] a, input logic [31:0] d);
    int wc;
    bit done;
    wc = 0; done = 1'b0;
    @(negedge clk);
    if (which == 0) begin c0_req = 1'b1; c0_we = we; c0_addr = a; c0_wdata = d; end
    else            begin c1_req = 1'b1; c1_we = we; c1_addr = a; c1_wdata = d; end
    while (!done) begin
      #1;
      if ((which == 0) ? c0_ack : c1_ack) begin
        rd_last = (which == 0) ? c0_rdata : c1_rdata;
        done = 1'b1;
      end else begin
        @(negedge clk);
        wc++;
      end
    end
    @(posedge clk);
    #1;
    if (which == 0) c0_req = 1'b0; else c1_req = 1'b0;
    wc_last = wc;
    if (we) begin
      if (which == 0) sm0[a[11:2]] = d; else sm1[a[11:2]] = d;
    end
  endtask

  task automatic load(input int which, input logic [31:0] a, input string req);
    logic [31:0] e;
    access(which, 1'b0, a, 32'h0);
    e = (which == 0) ? sm0[a[11:2]] : sm1[a[11:2]];
    check(rd_last == e, req, rd_last, e);
  endtask

  task automatic wait_quiet(input int which);
    int q;
    q = 0;
    while (q < 24) begin
      @(negedge clk);
      if ((which == 0) ? m0_wv : m1_wv) q = 0; else q++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f, w, maxwc;
    logic [31:0] a, d;
    bit we;
    for (int i = 0; i < 1024; i++) begin sm0[i] = 32'hC0DE_0000 + i; sm1[i] = 32'hC0DE_0000 + i; end
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state at the ports
    check(!c0_ack && !m0_rv && !m0_wv, "R4 reset outputs u0", {29'd0, c0_ack, m0_rv, m0_wv}, 32'd0);
    check(!c1_ack && !m1_rv && !m1_wv, "R4 reset outputs u1", {29'd0, c1_ack, m1_rv, m1_wv}, 32'd0);

    // R4 R3: first read misses and fills one line
    f = mm0.fills;
    load(0, 32'h000, "R3 miss data");
    check(mm0.fills == f + 1, "R4 first access misses", mm0.fills, f + 1);
    check(wc_last > 8, "R3 fill latency", wc_last, 9);
    // R2: same line hits with no wait
    f = mm0.fills;
    load(0, 32'h01C, "R2 hit data");
    check(wc_last == 0 && mm0.fills == f, "R2 hit in request cycle", wc_last, 0);
    // R1: same index other tag conflicts, other index does not
    f = mm0.fills;
    load(0, 32'h080, "R1 conflict data");
    load(0, 32'h020, "R1 other index data");
    check(mm0.fills == f + 2, "R1 two misses", mm0.fills, f + 2);
    load(0, 32'h080, "R1 rehit data");
    check(mm0.fills == f + 2 && wc_last == 0, "R1 index isolation", mm0.fills, f + 2);
    // R5: store hit stays in cache
    w = mm0.writes;
    access(0, 1'b1, 32'h084, 32'hDEAD_0001);
    wait_quiet(0);
    check(mm0.writes == w, "R5 no memory write", mm0.writes, w);
    check(mm0.mem[33] == 32'hC0DE_0021, "R5 memory untouched", mm0.mem[33], 32'hC0DE_0021);
    load(0, 32'h084, "R5 cache updated");
    // R6: dirty eviction writes eight words
    f = mm0.fills;
    load(0, 32'h004, "R6 refill data");
    check(mm0.writes == w + 8, "R6 dirty victim eight writes", mm0.writes, w + 8);
    check(mm0.mem[33] == 32'hDEAD_0001, "R6 victim word", mm0.mem[33], 32'hDEAD_0001);
    check(mm0.mem[39] == 32'hC0DE_0027, "R6 victim tail word", mm0.mem[39], 32'hC0DE_0027);
    // R6: clean victim no writes
    w = mm0.writes;
    load(0, 32'h100, "R6 clean replace data");
    check(mm0.writes == w, "R6 clean victim", mm0.writes, w);
    // R9: write-allocate store miss
    f = mm0.fills;
    access(0, 1'b1, 32'h188, 32'hBEEF_0188);
    check(mm0.fills == f + 1 && mm0.writes == w, "R9 allocate fetch", mm0.fills, f + 1);
    load(0, 32'h188, "R9 allocated word");
    check(wc_last == 0, "R9 line now hits", wc_last, 0);
    load(0, 32'h008, "R9 refill data");
    check(mm0.writes == w + 8 && mm0.mem[98] == 32'hBEEF_0188, "R9 dirty after allocate", mm0.mem[98], 32'hBEEF_0188);
    // R3 R5 R6 R9 sweep
    for (int n = 0; n < 240; n++) begin
      a = 32'(((n * 37 + (n / 4) * 13) % 1024) * 4);
      we = (n % 3 == 1);
      d = 32'h5A00_0000 + 32'(n);
      if (we) access(0, 1'b1, a, d);
      else load(0, a, "R6 sweep load");
    end

    // R10: no-allocate store miss
    f = mm1.fills;
    access(1, 1'b1, 32'h040, 32'hA1A1_0040);
    check(mm1.fills == f, "R10 no fetch on store miss", mm1.fills, f);
    wait_quiet(1);
    check(mm1.mem[16] == 32'hA1A1_0040, "R10 memory written", mm1.mem[16], 32'hA1A1_0040);
    load(1, 32'h040, "R10 read back");
    check(mm1.fills == f + 1, "R10 cache unchanged", mm1.fills, f + 1);
    // R7: write-through store hit
    w = mm1.writes; f = mm1.fills;
    access(1, 1'b1, 32'h044, 32'hA2A2_0044);
    wait_quiet(1);
    check(mm1.writes == w + 1 && mm1.fills == f, "R7 one write", mm1.writes, w + 1);
    check(mm1.mem[17] == 32'hA2A2_0044, "R7 memory word", mm1.mem[17], 32'hA2A2_0044);
    load(1, 32'h044, "R7 cache word");
    check(wc_last == 0, "R7 still hit", wc_last, 0);
    // R8: burst of stores fills the queue
    w = mm1.writes; maxwc = 0;
    for (int k = 0; k < 6; k++) begin
      access(1, 1'b1, 32'h040 + 32'(4 * k), 32'hB000_0000 + 32'(k));
      if (wc_last > maxwc) maxwc = wc_last;
    end
    check(maxwc > 0, "R8 stall when full", maxwc, 1);
    access(1, 1'b1, 32'h048, 32'hB0B0_0048);
    wait_quiet(1);
    check(mm1.writes == w + 7, "R8 all stores drained", mm1.writes, w + 7);
    check(mm1.mem[18] == 32'hB0B0_0048, "R7 in-order drain", mm1.mem[18], 32'hB0B0_0048);
    // R11: read waits for queued store to same line
    access(1, 1'b1, 32'h300, 32'hC1C1_0300);
    access(1, 1'b1, 32'h2A0, 32'hC2C2_02A0);
    load(1, 32'h2A0, "R11 fetch after drain");
    // R10 R7 sweep
    for (int n = 0; n < 150; n++) begin
      a = 32'(((n * 53 + 7) % 256) * 4);
      we = (n % 2 == 0);
      d = 32'h6B00_0000 + 32'(n);
      if (we) access(1, 1'b1, a, d);
      else load(1, a, "R7 sweep load");
    end
    wait_quiet(1);
    check(hold_bad == 0, "R12 write hold", hold_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule